// File: doc/BRIEF.md
# JTAG Scan Master Engine

This block is a hardware host for a single JTAG chain. It generates TCK, TMS and TDI from a system clock, samples TDO, and keeps its own copy of the 16-state TAP controller state. One command is executed at a time. A command is launched with a one-cycle `start` pulse, and a one-cycle `done` pulse reports that it has finished.

There are four command kinds. The first moves the TAP to a stable state. The second goes to Run-Test/Idle, runs N idle clocks there, and then moves on. The third gives N clocks without changing state. The fourth is an instruction or data scan of 1 to `MAX_BITS` bits. Scan data enters as a parallel word and leaves as a parallel word, with bit i on the i-th shift clock. The TMS route between states is worked out one step at a time from the current state and the target, so no path table is stored. Each TCK half-period lasts `div+1` system clocks.

Top module: `tap_scan_engine`

## Requirements
- R1: TCK is low whenever `busy` is low. After the last TCK falling edge of a command, TCK stays low until `done`.
- R2: TMS and TDI change only while TCK is low. Each TCK high phase lasts exactly `div+1` system clocks, where `div` is captured at `start`.
- R3: Command codes are: 0 move, 1 run-test, 2 stable clocks, 3 scan. TAP state codes are: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. A move drives the TMS route to the requested end state. It gives no clocks if the TAP is already there. `tap_now` follows the TAP on every TCK rising edge.
- R4: The stable states are 0, 1, 4, 6, 11 and 13. A move, run-test or scan that names any other end state raises `err` together with `done` and produces no TCK. The same happens for a scan of length 0 or of length greater than `MAX_BITS`.
- R5: Run-test first moves to Run-Test/Idle if the TAP is elsewhere. It then gives `count` clocks with TMS=0 and TDI=0, and then moves to the end state. TDI is 0 on every clock that does not carry scan data.
- R6: Stable clocks gives `count` clocks with TMS=1 in Test-Logic-Reset and TMS=0 in any other state. It leaves the state unchanged and ignores `end_state`.
- R7: A scan first moves to Shift-IR (`scan_ir`=1) or Shift-DR (`scan_ir`=0) if the TAP is not already in that state. TMS is 0 on every data bit except the last, which has TMS=1. The move to the end state then starts from Exit1, so the shift exit is not repeated. For example, an end state of Idle adds exactly two clocks, with TMS 1 then 0.
- R8: Scan bits are LSB first. On the i-th data clock TDI carries `din[i]`. The TDO value present just before that rising edge is stored in `dout[i]`. Bits of `dout` at and above the scan length read 0.
- R9: `scan_type` bit 0 enables sending `din`. When it is 0 (capture-only), TDI is 0. `scan_type` bit 1 enables capture. When it is 0 (output-only), `dout` reads all zeros after the scan.
- R10: A scan that starts with the TAP already in the matching shift state gives no clocks before the first data bit.
- R11: `done` is high for exactly one cycle. `tap_now` names a stable state whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; TAP assumed in Test-Logic-Reset |
| start | input | 1 | Launch command (sampled when not busy) |
| cmd | input | 2 | Command kind |
| end_state | input | 4 | Requested final TAP state |
| count | input | CNT_W | Clock count or scan length |
| scan_ir | input | 1 | 1 selects the instruction register |
| scan_type | input | 2 | Bit 0 send, bit 1 capture |
| din | input | MAX_BITS | Scan data out to TDI, LSB first |
| div | input | DIV_W | TCK half-period minus one, in system clocks |
| dout | output | MAX_BITS | Captured TDO bits |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected command, high with done |
| tap_now | output | 4 | Tracked TAP state |
| tck | output | 1 | JTAG clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to chain |
| tdo | input | 1 | JTAG data from chain |

## Verification
`tap_now` and TCK rise on the same system clock edge. The bench's TAP follower advances on that TCK edge, so the two states are compared half a cycle later, on every falling edge of `clk`. A rejected command raises `done` and `err` on the first edge after `start`. An accepted command raises `done` one `div+1` tail after its last TCK fall. The bench therefore waits for `done`, not for a fixed count. Only once `done` is seen does it compare the TMS/TDI strings recorded at every TCK rise, the `err` flag and `dout`. It then checks one cycle later that `done` has dropped. The TCK high width is measured in system clocks on each falling edge of `clk`.

// File: rtl/tap_scan_engine.sv
`timescale 1ns/1ps
module tap_scan_engine #(
  parameter int MAX_BITS = 64,
  parameter int CNT_W    = 16,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          cmd,
  input  logic [3:0]          end_state,
  input  logic [CNT_W-1:0]    count,
  input  logic                scan_ir,
  input  logic [1:0]          scan_type,
  input  logic [MAX_BITS-1:0] din,
  input  logic [DIV_W-1:0]    div,
  output logic [MAX_BITS-1:0] dout,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [3:0]          tap_now,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  input  logic                tdo
);
  localparam int IW = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  localparam logic [1:0] OP_MOVE = 2'd0, OP_RUN = 2'd1, OP_CLK = 2'd2, OP_SCAN = 2'd3;
  localparam logic [3:0] T_RESET = 4'd0,  T_IDLE = 4'd1,  T_SELDR = 4'd2,  T_CAPDR = 4'd3,
                         T_SHDR  = 4'd4,  T_EX1DR = 4'd5, T_PADR = 4'd6,   T_EX2DR = 4'd7,
                         T_UPDR  = 4'd8,  T_SELIR = 4'd9, T_CAPIR = 4'd10, T_SHIR = 4'd11,
                         T_EX1IR = 4'd12, T_PAIR = 4'd13, T_EX2IR = 4'd14, T_UPIR = 4'd15;

  typedef enum logic [2:0] {E_IDLE, E_DECIDE, E_LOW, E_HIGH, E_TAIL} eng_t;
  typedef enum logic [1:0] {P_PRE, P_BODY, P_POST} phase_t;

  function automatic logic is_stable(input logic [3:0] s);
    return s == T_RESET || s == T_IDLE || s == T_SHDR || s == T_PADR || s == T_SHIR || s == T_PAIR;
  endfunction

  function automatic logic [3:0] tap_next(input logic [3:0] s, input logic m);
    case (s)
      T_RESET: return m ? T_RESET : T_IDLE;
      T_IDLE:  return m ? T_SELDR : T_IDLE;
      T_SELDR: return m ? T_SELIR : T_CAPDR;
      T_CAPDR: return m ? T_EX1DR : T_SHDR;
      T_SHDR:  return m ? T_EX1DR : T_SHDR;
      T_EX1DR: return m ? T_UPDR  : T_PADR;
      T_PADR:  return m ? T_EX2DR : T_PADR;
      T_EX2DR: return m ? T_UPDR  : T_SHDR;
      T_UPDR:  return m ? T_SELDR : T_IDLE;
      T_SELIR: return m ? T_RESET : T_CAPIR;
      T_CAPIR: return m ? T_EX1IR : T_SHIR;
      T_SHIR:  return m ? T_EX1IR : T_SHIR;
      T_EX1IR: return m ? T_UPIR  : T_PAIR;
      T_PAIR:  return m ? T_EX2IR : T_PAIR;
      T_EX2IR: return m ? T_UPIR  : T_SHIR;
      default: return m ? T_SELDR : T_IDLE;
    endcase
  endfunction

  // next TMS bit on the route from c toward stable target t
  function automatic logic route_tms(input logic [3:0] c, input logic [3:0] t);
    if (t == T_RESET) return 1'b1;
    case (c)
      T_RESET:        return 1'b0;
      T_SELDR:        return !(t == T_SHDR || t == T_PADR || t == T_IDLE);
      T_SELIR:        return 1'b0;
      T_CAPDR:        return t != T_SHDR;
      T_EX1DR:        return !(t == T_PADR || t == T_SHDR);
      T_EX2DR:        return t != T_SHDR;
      T_UPDR, T_UPIR: return t != T_IDLE;
      T_CAPIR:        return t != T_SHIR;
      T_EX1IR:        return !(t == T_PAIR || t == T_SHIR);
      T_EX2IR:        return t != T_SHIR;
      default:        return 1'b1;
    endcase
  endfunction

  eng_t                est;
  phase_t              ph, nph;
  logic [1:0]          op, stype;
  logic                ir_q, cap_q, tck_q, tms_q, tdi_q;
  logic [3:0]          tap_q, tgt_end, pre_tgt;
  logic [CNT_W-1:0]    remain;
  logic [IW-1:0]       bidx, cap_idx;
  logic [DIV_W-1:0]    hc, div_q;
  logic [MAX_BITS-1:0] sin, sout;
  logic                emit, e_tms, e_tdi, e_cap, to_tail, reject;

  assign busy    = est != E_IDLE;
  assign tck     = tck_q;
  assign tms     = tms_q;
  assign tdi     = tdi_q;
  assign tap_now = tap_q;
  assign dout    = sout;
  assign pre_tgt = (op == OP_RUN) ? T_IDLE : (op == OP_SCAN) ? (ir_q ? T_SHIR : T_SHDR) : tgt_end;
  assign reject  = (cmd != OP_CLK && !is_stable(end_state)) ||
                   (cmd == OP_SCAN && (count == '0 || count > CNT_W'(MAX_BITS)));

  always_comb begin
    emit = 1'b0; e_tms = 1'b0; e_tdi = 1'b0; e_cap = 1'b0; to_tail = 1'b0; nph = ph;
    case (ph)
      P_PRE:
        if (tap_q == pre_tgt) nph = P_BODY;
        else begin emit = 1'b1; e_tms = route_tms(tap_q, pre_tgt); end
      P_BODY:
        if (op == OP_MOVE || remain == '0) nph = P_POST;
        else begin
          emit = 1'b1;
          if (op == OP_SCAN) begin
            e_tms = remain == CNT_W'(1);
            e_tdi = stype[0] & sin[bidx];
            e_cap = stype[1];
          end else e_tms = (op == OP_CLK) && (tap_q == T_RESET);
        end
      default:
        if (tap_q == tgt_end) to_tail = 1'b1;
        else begin emit = 1'b1; e_tms = route_tms(tap_q, tgt_end); end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est <= E_IDLE; ph <= P_PRE; op <= OP_MOVE; stype <= 2'b00; ir_q <= 1'b0;
      cap_q <= 1'b0; tck_q <= 1'b0; tms_q <= 1'b0; tdi_q <= 1'b0;
      tap_q <= T_RESET; tgt_end <= T_RESET; remain <= '0; bidx <= '0; cap_idx <= '0;
      hc <= '0; div_q <= '0; sin <= '0; sout <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (est)
        E_IDLE:
          if (start) begin
            if (reject) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              op <= cmd; stype <= scan_type; ir_q <= scan_ir; remain <= count;
              tgt_end <= (cmd == OP_CLK) ? tap_q : end_state;
              bidx <= '0; sin <= din; sout <= '0; div_q <= div; ph <= P_PRE;
              est <= E_DECIDE;
            end
          end
        E_DECIDE: begin
          ph <= nph;
          hc <= '0;
          if (emit) begin
            tms_q <= e_tms; tdi_q <= e_tdi; cap_q <= e_cap; cap_idx <= bidx;
            if (ph == P_BODY) begin
              remain <= remain - CNT_W'(1);
              bidx   <= bidx + IW'(1);
            end
            est <= E_LOW;
          end else if (to_tail) est <= E_TAIL;
        end
        E_LOW:
          if (hc == div_q) begin
            tck_q <= 1'b1;
            tap_q <= tap_next(tap_q, tms_q);
            if (cap_q) sout[cap_idx] <= tdo;
            hc  <= '0;
            est <= E_HIGH;
          end else hc <= hc + DIV_W'(1);
        E_HIGH:
          if (hc == div_q) begin
            tck_q <= 1'b0;
            hc    <= '0;
            est   <= E_DECIDE;
          end else hc <= hc + DIV_W'(1);
        default:
          if (hc == div_q) begin
            tdi_q <= 1'b0;
            done  <= 1'b1;
            est   <= E_IDLE;
          end else hc <= hc + DIV_W'(1);
      endcase
    end
  end

  AST_IDLE_TCK_LOW:    assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !tck);                          // R1
  AST_PINS_HOLD_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) tck |-> ($stable(tms) && $stable(tdi))); // R2
  AST_TAP_ON_RISE:     assert property (@(posedge clk) disable iff (!rst_n) !$stable(tap_now) |-> $rose(tck));       // R3
  AST_ERR_WITH_DONE:   assert property (@(posedge clk) disable iff (!rst_n) err |-> (done && !tck));                 // R4
  AST_DONE_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                         // R11
  AST_DONE_IN_STABLE:  assert property (@(posedge clk) disable iff (!rst_n) done |-> is_stable(tap_now));            // R11
endmodule

// File: tb/sim_tap_scan_engine.sv
`timescale 1ns/1ps
module sim_tap_scan_engine;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, scan_ir = 1'b0;
  logic [1:0]  cmd = 2'd0, scan_type = 2'd0;
  logic [3:0]  end_state = 4'd0;
  logic [15:0] count = 16'd0;
  logic [63:0] din = 64'd0;
  logic [7:0]  div = 8'd1;
  logic [63:0] dout;
  logic        busy, done, err, tck, tms, tdi, tdo;
  logic [3:0]  tap_now;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tap_scan_engine u0 (.clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .end_state(end_state),
    .count(count), .scan_ir(scan_ir), .scan_type(scan_type), .din(din), .div(div), .dout(dout),
    .busy(busy), .done(done), .err(err), .tap_now(tap_now), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

  // behavioural TAP device on the chain
  logic [3:0]  nx0 [16];
  logic [3:0]  nx1 [16];
  logic [3:0]  m_st = 4'd0;
  logic [63:0] m_dr = 64'h0123_4567_89AB_CDEF;
  logic [63:0] m_ir = 64'h0000_0000_0000_0009;
  logic [63:0] m_cap;
  int          m_ncap = 0;
  string       rec_tms = "", rec_tdi = "";
  int          hi_run = 0, last_hi = 0;

  assign tdo = (m_st == 4'd11) ? m_ir[0] : m_dr[0];

  initial begin
    nx0 = '{4'd1, 4'd1, 4'd3, 4'd4, 4'd4, 4'd6, 4'd6, 4'd4, 4'd1, 4'd10, 4'd11, 4'd11, 4'd13, 4'd13, 4'd11, 4'd1};
    nx1 = '{4'd0, 4'd2, 4'd9, 4'd5, 4'd5, 4'd8, 4'd7, 4'd8, 4'd2, 4'd0, 4'd12, 4'd12, 4'd15, 4'd14, 4'd15, 4'd2};
  end

  always @(posedge tck) begin
    rec_tms = {rec_tms, tms ? "1" : "0"};
    rec_tdi = {rec_tdi, tdi ? "1" : "0"};
    if (m_st == 4'd4 || m_st == 4'd11) begin
      if (m_ncap < 64) m_cap[m_ncap] = tdo;
      m_ncap++;
      if (m_st == 4'd4) m_dr = {tdi, m_dr[63:1]};
      else              m_ir = {tdi, m_ir[63:1]};
    end
    m_st = tms ? nx1[m_st] : nx0[m_st];
  end

  task automatic check(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tap_now == m_st, $sformatf("R3 tap_now got %0d exp %0d", tap_now, m_st));
      if (!busy) check(!tck, $sformatf("R1 tck while idle got %0b exp 0", tck));
    end
    if (tck) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  function automatic string bstr(input logic [63:0] d, input int n);
    string s = "";
    for (int i = 0; i < n; i++) s = {s, d[i] ? "1" : "0"};
    return s;
  endfunction

  function automatic string rep(input string c, input int n);
    string s = "";
    for (int i = 0; i < n; i++) s = {s, c};
    return s;
  endfunction

  task automatic do_cmd(input logic [1:0] c, input logic [3:0] e, input int n, input logic ir,
                        input logic [1:0] st, input logic [63:0] d, input bit x_err,
                        input string x_tms, input string x_tdi, input string req);
    int guard = 0;
    logic [63:0] x_dout;
    rec_tms = ""; rec_tdi = ""; m_cap = '0; m_ncap = 0;
    @(negedge clk);
    cmd = c; end_state = e; count = 16'(n); scan_ir = ir; scan_type = st; din = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    if (!done) begin
      check(1'b0, $sformatf("%s done got 0 exp 1", req));
      return;
    end
    check(err == x_err, $sformatf("%s err got %0b exp %0b", req, err, x_err));
    check(rec_tms == x_tms, $sformatf("%s tms got '%s' exp '%s'", req, rec_tms, x_tms));
    check(rec_tdi == x_tdi, $sformatf("%s tdi got '%s' exp '%s'", req, rec_tdi, x_tdi));
    if (c == 2'd3 && !x_err) begin
      x_dout = st[1] ? m_cap : 64'd0;
      check(dout == x_dout, $sformatf("%s dout got %h exp %h", req, dout, x_dout));
    end
    @(negedge clk);
    check(!done, $sformatf("R11 done second cycle got %0b exp 0", done));
  endtask

  initial begin
    string t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tck && !busy && !done && tap_now == 4'd0 && dout == 64'd0,
          $sformatf("R1 reset tck=%0b busy=%0b done=%0b tap=%0d exp 0 0 0 0", tck, busy, done, tap_now));

    do_cmd(2'd0, 4'd1, 0, 1'b0, 2'd0, 64'd0, 1'b0, "0", "0", "R3 move reset->idle");
    do_cmd(2'd0, 4'd1, 0, 1'b0, 2'd0, 64'd0, 1'b0, "", "", "R3 move to current state");
    do_cmd(2'd0, 4'd3, 0, 1'b0, 2'd0, 64'd0, 1'b1, "", "", "R4 non-stable end state");

    do_cmd(2'd3, 4'd1, 8, 1'b0, 2'd3, 64'hA5, 1'b0, "1000000000110",
           {"000", bstr(64'hA5, 8), "00"}, "R7 R8 dr scan 8");
    check(dout[7:0] == 8'hEF, $sformatf("R8 first dr capture got %h exp ef", dout[7:0]));

    do_cmd(2'd3, 4'd13, 4, 1'b1, 2'd2, 64'hF, 1'b0, "110000010", "000000000", "R9 capture-only ir scan");
    check(dout[3:0] == 4'h9, $sformatf("R9 ir capture got %h exp 9", dout[3:0]));

    do_cmd(2'd3, 4'd4, 5, 1'b0, 2'd1, 64'h16, 1'b0, "1110000001010",
           {"00000", bstr(64'h16, 5), "000"}, "R9 output-only scan end shift-dr");
    do_cmd(2'd3, 4'd1, 3, 1'b0, 2'd3, 64'h3, 1'b0, "00110",
           {bstr(64'h3, 3), "00"}, "R10 scan from shift-dr");

    do_cmd(2'd1, 4'd1, 3, 1'b0, 2'd0, 64'd0, 1'b0, "000", "000", "R5 runtest in idle");
    do_cmd(2'd0, 4'd6, 0, 1'b0, 2'd0, 64'd0, 1'b0, "1010", "0000", "R3 move to pause-dr");
    do_cmd(2'd1, 4'd13, 2, 1'b0, 2'd0, 64'd0, 1'b0, "1100011010", "0000000000", "R5 runtest from pause-dr");

    do_cmd(2'd2, 4'd3, 4, 1'b0, 2'd0, 64'd0, 1'b0, "0000", "0000", "R6 clocks in pause-ir");
    do_cmd(2'd0, 4'd0, 0, 1'b0, 2'd0, 64'd0, 1'b0, "11111", "00000", "R3 move to reset");
    do_cmd(2'd2, 4'd1, 3, 1'b0, 2'd0, 64'd0, 1'b0, "111", "000", "R6 clocks in reset");

    do_cmd(2'd3, 4'd1, 0, 1'b0, 2'd3, 64'd0, 1'b1, "", "", "R4 scan length 0");
    do_cmd(2'd3, 4'd1, 65, 1'b0, 2'd3, 64'd0, 1'b1, "", "", "R4 scan length over max");

    do_cmd(2'd1, 4'd1, 0, 1'b0, 2'd0, 64'd0, 1'b0, "0", "0", "R5 runtest zero cycles");

    div = 8'd3;
    do_cmd(2'd2, 4'd1, 2, 1'b0, 2'd0, 64'd0, 1'b0, "00", "00", "R2 clocks with div 3");
    check(last_hi == 4, $sformatf("R2 tck high width got %0d exp 4", last_hi));
    div = 8'd1;

    t = {"100", rep("0", 63), "1", "10"};
    do_cmd(2'd3, 4'd1, 64, 1'b0, 2'd3, 64'hF0E1_D2C3_B4A5_9687, 1'b0, t,
           {"000", bstr(64'hF0E1_D2C3_B4A5_9687, 64), "00"}, "R8 full-width dr scan");
    check(busy == 1'b0 && tck == 1'b0, $sformatf("R1 after scan busy=%0b tck=%0b exp 0 0", busy, tck));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule